// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Logic

This block produces the two mailbox interrupts of a shared memory that two agents, a left port and a right port, access. The memory array itself sits elsewhere. The block watches the same access strobes and addresses that the array receives. The two highest locations of the address space are the mailboxes. When one port stores a word into the mailbox that belongs to its peer, the peer's interrupt line drops. When the peer then reads that mailbox, its line rises again. The mailbox words stay ordinary data locations, and the block never stalls or alters any access.

Both ports are sampled on the rising edge of one shared clock. Each interrupt line is a register output, so it moves one edge after the access that causes the change. A port whose busy input from the arbiter is asserted cannot set or clear any flag during that cycle. The address width is a parameter. The mailboxes are always the all-ones address and the address just below it, so a 12-bit build uses 0xFFF and 0xFFE and a 13-bit build uses 0x1FFF and 0x1FFE.

Top module: `mbx_irq_top`

## Requirements
- R1: While the synchronous active-high reset is sampled high, both interrupt outputs are high on the next edge, whatever the ports are doing.
- R2: A left write (l_cs_n=0, l_wr_n=0) to address all-ones with l_busy_n=1 drives r_irq_n low after that edge.
- R3: A right read (r_cs_n=0, r_wr_n=1, r_oe_n=0) of address all-ones with r_busy_n=1 returns r_irq_n high after that edge, unless R7 applies.
- R4: A right write (r_cs_n=0, r_wr_n=0) to address all-ones minus one with r_busy_n=1 drives l_irq_n low after that edge.
- R5: A left read (l_cs_n=0, l_wr_n=1, l_oe_n=0) of address all-ones minus one with l_busy_n=1 returns l_irq_n high after that edge, unless R7 applies.
- R6: When the acting port's busy input is low, its access leaves the flag it would have set or cleared unchanged.
- R7: If one flag sees a set and a clear in the same cycle, the set wins and the interrupt output goes or stays low.
- R8: Accesses have no effect on either flag when chip select is high, when a read has output enable high, when a port reads the mailbox of the other port, or when a port writes the mailbox it itself receives on.
- R9: The mailboxes are the all-ones address and the all-ones minus one address of the ADDR_W-bit address. With ADDR_W=12 these are 0xFFF and 0xFFE, and an address such as 0x7FF is not a mailbox.
- R10: With no set or clear, an interrupt output keeps its value from cycle to cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| l_cs_n | input | 1 | Left chip enable, active low |
| l_wr_n | input | 1 | Left read/write select, low means write |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | ADDR_W | Left address |
| l_busy_n | input | 1 | Left busy from arbiter, active low |
| l_irq_n | output | 1 | Interrupt toward left port, active low |
| r_cs_n | input | 1 | Right chip enable, active low |
| r_wr_n | input | 1 | Right read/write select, low means write |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | ADDR_W | Right address |
| r_busy_n | input | 1 | Right busy from arbiter, active low |
| r_irq_n | output | 1 | Interrupt toward right port, active low |

## Verification
The assertions check on every cycle that a raising write drives the peer line low, that a clearing read raises the line when no set competes, that a set beats a clear, that a line holds with no event, that busy on both ports freezes both lines, and that reset releases both lines. The bench scenarios cover the cases that need a sequence of accesses. These include ignored accesses with output enable high, with the wrong port or with a non-mailbox address, busy on only the acting port, and the 12-bit mailbox positions. They also include reset arriving while a raising write is present.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  typedef enum logic {
    SIDE_LEFT  = 1'b0,
    SIDE_RIGHT = 1'b1
  } side_e;

  localparam int NUM_SIDES = 2;

  // event pulses produced by one port's decoder
  typedef struct packed {
    logic raise_peer;  // write to the peer's mailbox
    logic ack_own;     // read of own mailbox
  } port_evt_t;

  // offset below all-ones of the mailbox a side receives on
  function automatic int rx_offset(input int side);
    return (side == int'(SIDE_LEFT)) ? 1 : 0;
  endfunction

endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
  import mbx_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int SIDE   = 0
) (
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              busy_n,
  output port_evt_t         evt
);

  localparam logic [ADDR_W-1:0] ALL_ONES = {ADDR_W{1'b1}};
  localparam int              OWN_OFF  = rx_offset(SIDE);
  localparam int              PEER_OFF = rx_offset(NUM_SIDES - 1 - SIDE);
  localparam logic [ADDR_W-1:0] OWN_BOX  = ALL_ONES - ADDR_W'(OWN_OFF);
  localparam logic [ADDR_W-1:0] PEER_BOX = ALL_ONES - ADDR_W'(PEER_OFF);

  logic is_write;
  logic is_read;

  always_comb begin
    is_write       = !cs_n && !wr_n;
    is_read        = !cs_n && wr_n && !oe_n;
    evt.raise_peer = busy_n && is_write && (addr == PEER_BOX);
    evt.ack_own    = busy_n && is_read  && (addr == OWN_BOX);
  end

endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_n
);

  always_ff @(posedge clk) begin
    if (rst)        irq_n <= 1'b1;
    else if (set_i) irq_n <= 1'b0;
    else if (clr_i) irq_n <= 1'b1;
  end

  p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
    set_i |=> !irq_n);

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!set_i && !clr_i) |=> $stable(irq_n));

  p_reset_r1: assert property (@(posedge clk)
    rst |=> irq_n);

endmodule

// File: rtl/mbx_irq_top.sv
module mbx_irq_top
  import mbx_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              l_cs_n,
  input  logic              l_wr_n,
  input  logic              l_oe_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_busy_n,
  output logic              l_irq_n,
  input  logic              r_cs_n,
  input  logic              r_wr_n,
  input  logic              r_oe_n,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_busy_n,
  output logic              r_irq_n
);

  localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] NXT_ADDR = TOP_ADDR - 1'b1;

  logic [NUM_SIDES-1:0]             cs_n_a, wr_n_a, oe_n_a, busy_n_a, irq_n_a;
  logic [NUM_SIDES-1:0][ADDR_W-1:0] addr_a;
  port_evt_t [NUM_SIDES-1:0]        evt_a;

  assign cs_n_a   = {r_cs_n,   l_cs_n};
  assign wr_n_a   = {r_wr_n,   l_wr_n};
  assign oe_n_a   = {r_oe_n,   l_oe_n};
  assign busy_n_a = {r_busy_n, l_busy_n};
  assign addr_a   = {r_addr,   l_addr};

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    mbx_port_decode #(
      .ADDR_W (ADDR_W),
      .SIDE   (s)
    ) u_dec (
      .cs_n   (cs_n_a[s]),
      .wr_n   (wr_n_a[s]),
      .oe_n   (oe_n_a[s]),
      .addr   (addr_a[s]),
      .busy_n (busy_n_a[s]),
      .evt    (evt_a[s])
    );

    mbx_flag u_flag (
      .clk   (clk),
      .rst   (rst),
      .set_i (evt_a[NUM_SIDES-1-s].raise_peer),
      .clr_i (evt_a[s].ack_own),
      .irq_n (irq_n_a[s])
    );
  end

  assign l_irq_n = irq_n_a[SIDE_LEFT];
  assign r_irq_n = irq_n_a[SIDE_RIGHT];

  p_left_raise_r2: assert property (@(posedge clk) disable iff (rst)
    (!l_cs_n && !l_wr_n && l_busy_n && l_addr == TOP_ADDR) |=> !r_irq_n);

  p_right_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (!r_cs_n && r_wr_n && !r_oe_n && r_busy_n && r_addr == TOP_ADDR &&
     !(!l_cs_n && !l_wr_n && l_busy_n && l_addr == TOP_ADDR)) |=> r_irq_n);

  p_right_raise_r4: assert property (@(posedge clk) disable iff (rst)
    (!r_cs_n && !r_wr_n && r_busy_n && r_addr == NXT_ADDR) |=> !l_irq_n);

  p_left_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (!l_cs_n && l_wr_n && !l_oe_n && l_busy_n && l_addr == NXT_ADDR &&
     !(!r_cs_n && !r_wr_n && r_busy_n && r_addr == NXT_ADDR)) |=> l_irq_n);

  p_busy_freeze_r6: assert property (@(posedge clk) disable iff (rst)
    (!l_busy_n && !r_busy_n) |=> ($stable(l_irq_n) && $stable(r_irq_n)));

endmodule

// File: tb/test_mbx_irq_top.sv
module test_mbx_irq_top;

  localparam int AW = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic l_cs_n = 1'b1, l_wr_n = 1'b1, l_oe_n = 1'b1, l_busy_n = 1'b1;
  logic r_cs_n = 1'b1, r_wr_n = 1'b1, r_oe_n = 1'b1, r_busy_n = 1'b1;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic l_irq_n, r_irq_n;

  always #5 clk = ~clk;

  mbx_irq_top #(.ADDR_W(AW)) i_mbx_irq_top (
    .clk(clk), .rst(rst),
    .l_cs_n(l_cs_n), .l_wr_n(l_wr_n), .l_oe_n(l_oe_n), .l_addr(l_addr),
    .l_busy_n(l_busy_n), .l_irq_n(l_irq_n),
    .r_cs_n(r_cs_n), .r_wr_n(r_wr_n), .r_oe_n(r_oe_n), .r_addr(r_addr),
    .r_busy_n(r_busy_n), .r_irq_n(r_irq_n)
  );

  // one port's stimulus: cs_n, wr_n, oe_n, addr, busy_n
  typedef struct packed {
    logic       cs_n;
    logic       wr_n;
    logic       oe_n;
    logic [15:0] addr;
    logic       busy_n;
  } pin_t;

  typedef struct packed {
    pin_t       lp;
    pin_t       rp;
    logic       exp_l;
    logic       exp_r;
    logic [3:0] req;
  } vec_t;

  localparam pin_t IDLE = '{1'b1, 1'b1, 1'b1, 16'h0000, 1'b1};

  function automatic pin_t wr(input logic [15:0] a, input logic b);
    return '{1'b0, 1'b0, 1'b1, a, b};
  endfunction
  function automatic pin_t rd(input logic [15:0] a, input logic b);
    return '{1'b0, 1'b1, 1'b0, a, b};
  endfunction

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{wr(16'hFFF,1), IDLE,            1'b1, 1'b0, 4'd2 },
    '{IDLE,          IDLE,            1'b1, 1'b0, 4'd10},
    '{rd(16'hFFF,1), IDLE,            1'b1, 1'b0, 4'd8 },
    '{IDLE, '{1'b0,1'b1,1'b1,16'hFFF,1'b1}, 1'b1, 1'b0, 4'd8},
    '{IDLE,          rd(16'hFFF,0),   1'b1, 1'b0, 4'd6 },
    '{IDLE,          rd(16'hFFF,1),   1'b1, 1'b1, 4'd3 },
    '{IDLE,          wr(16'hFFE,1),   1'b0, 1'b1, 4'd4 },
    '{wr(16'hFFE,1), IDLE,            1'b0, 1'b1, 4'd8 },
    '{rd(16'hFFE,0), IDLE,            1'b0, 1'b1, 4'd6 },
    '{rd(16'hFFE,1), IDLE,            1'b1, 1'b1, 4'd5 },
    '{wr(16'h7FF,1), IDLE,            1'b1, 1'b1, 4'd9 },
    '{wr(16'hFFF,0), IDLE,            1'b1, 1'b1, 4'd6 },
    '{IDLE, '{1'b1,1'b0,1'b1,16'hFFE,1'b1}, 1'b1, 1'b1, 4'd8},
    '{wr(16'hFFF,1), rd(16'hFFF,1),   1'b1, 1'b0, 4'd7 },
    '{rd(16'hFFE,1), wr(16'hFFE,1),   1'b0, 1'b0, 4'd7 },
    '{rd(16'hFFE,1), rd(16'hFFF,1),   1'b1, 1'b1, 4'd3 }
  };

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  function automatic string tag(input logic [3:0] r);
    case (r)
      4'd1:  return "R1";
      4'd2:  return "R2";
      4'd3:  return "R3";
      4'd4:  return "R4";
      4'd5:  return "R5";
      4'd6:  return "R6";
      4'd7:  return "R7";
      4'd8:  return "R8";
      4'd9:  return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic drive(input pin_t lp, input pin_t rp);
    l_cs_n = lp.cs_n; l_wr_n = lp.wr_n; l_oe_n = lp.oe_n;
    l_addr = lp.addr[AW-1:0]; l_busy_n = lp.busy_n;
    r_cs_n = rp.cs_n; r_wr_n = rp.wr_n; r_oe_n = rp.oe_n;
    r_addr = rp.addr[AW-1:0]; r_busy_n = rp.busy_n;
  endtask

  task automatic check(input logic el, input logic er, input string rq);
    checks++;
    if (l_irq_n !== el || r_irq_n !== er) begin
      fails++;
      $display("FAIL %s: l_irq_n=%b r_irq_n=%b expected %b %b",
               rq, l_irq_n, r_irq_n, el, er);
    end
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check(1'b1, 1'b1, "R1");          // reset state
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].lp, VECS[i].rp);
      @(negedge clk);
      check(VECS[i].exp_l, VECS[i].exp_r, tag(VECS[i].req));
    end
    // R6: busy on the other port does not block the acting port
    drive(wr(16'hFFF,1), '{1'b1,1'b1,1'b1,16'h0,1'b0});
    @(negedge clk);
    check(1'b1, 1'b0, "R6");
    // R10: long idle hold
    drive(IDLE, IDLE);
    repeat (5) @(negedge clk);
    check(1'b1, 1'b0, "R10");
    // R1: reset wins over a raising write in the same cycle
    drive(IDLE, wr(16'hFFE,1));
    @(negedge clk);
    check(1'b0, 1'b0, "R4");
    rst = 1'b1;
    drive(wr(16'hFFF,1), wr(16'hFFE,1));
    @(negedge clk);
    check(1'b1, 1'b1, "R1");
    rst = 1'b0;
    drive(IDLE, IDLE);
    @(negedge clk);
    check(1'b1, 1'b1, "R1");
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule